// File: doc/BRIEF.md
# SHA Message Schedule Helper Unit

This block evaluates the message-expansion steps that feed the SHA-1 and SHA-256 compression rounds. Each request carries two 128-bit operands, A and B, and a 3-bit operation code. Every operand holds four 32-bit lanes. The unit returns a 128-bit word holding four new schedule words, or a partial form of them that a later step completes. The compression rounds, register storage and instruction decoding are handled outside this block.

A request is accepted in any cycle in which `inValid` is high. The operands are captured at that clock edge. The result is computed from the captured copy and loaded into an output register at the next edge, and `outValid` rises with it. The pipeline takes a new request in every cycle. Between results the output register keeps its last value.

Top module: `sha_sched_unit`

## Requirements
- R1: While reset is asserted and after it is released, before any request, `outValid` is 0 and `result` is all zeros.
- R2: `outValid` is high exactly two clock edges after a cycle with `inValid` high, one cycle per request, so back-to-back requests give back-to-back results. `result` changes only on an edge that raises or holds `outValid`. Operand changes while `inValid` is low have no effect.
- R3: Code 0 (SHA-1 E update): lanes 0..2 of the result equal lanes 0..2 of B, and lane 3 equals B lane 3 plus A lane 3 rotated left by 30.
- R4: Code 1 (SHA-1 expansion, first half): with x0..x3 = A lanes 3..0 and x4,x5 = B lanes 3,2, the result lanes 3..0 are x0^x2, x1^x3, x2^x4 and x3^x5.
- R5: Code 2 (SHA-1 expansion, second half): p = rol1(A3^B2), q = rol1(A2^B1), r = rol1(A1^B0) and s = rol1(A0^p). The result lanes 3..0 are p, q, r and s. Lane 0 depends on the new lane 3.
- R6: Code 3 (SHA-256 expansion, first half): result lane i = A lane i + s0(A lane i+1) for i = 0..2, and lane 3 = A lane 3 + s0(B lane 0). Here s0(x) = ror7(x)^ror18(x)^shr3(x).
- R7: Code 4 (SHA-256 expansion, second half): lane 0 = A0 + s1(B2) and lane 1 = A1 + s1(B3). Lane 2 = A2 + s1(lane 0 result) and lane 3 = A3 + s1(lane 1 result). Here s1(x) = ror17(x)^ror19(x)^shr10(x).
- R8: Codes 5, 6 and 7 return operand A unchanged.
- R9: Lane n occupies bits 32n+31..32n. All sums are modulo 2^32, and no carry crosses a lane boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Request strobe; operands captured when high |
| opSel | input | 3 | Operation code (0..4 defined, 5..7 pass A) |
| srcA | input | 128 | Operand A, four 32-bit lanes |
| srcB | input | 128 | Operand B, four 32-bit lanes |
| outValid | output | 1 | Result valid, two edges after the request |
| result | output | 128 | Registered result |

## Verification
A wrong lane wiring or rotate amount shows as a bad `result` in the very cycle `outValid` rises, two edges after the request. The chained lanes of codes 2 and 4 spread an error in the first computed word into a second lane of that same result. A fault in the valid pipeline shows as `outValid` missing, doubled or shifted by a cycle, or as `result` moving while `outValid` is low. These are visible at the first request or the first idle gap after reset.

// File: rtl/sha_sched_pkg.sv
package sha_sched_pkg;
  localparam int LANE_W = 32;
  localparam int LANES  = 4;
  localparam int VEC_W  = LANE_W * LANES;
  localparam int OP_W   = 3;

  typedef logic [LANE_W-1:0] word_t;
  typedef logic [OP_W-1:0]   op_t;

  localparam op_t OP_S1_EUPD = 3'd0;
  localparam op_t OP_S1_XPA  = 3'd1;
  localparam op_t OP_S1_XPB  = 3'd2;
  localparam op_t OP_S2_XPA  = 3'd3;
  localparam op_t OP_S2_XPB  = 3'd4;

  typedef struct packed {
    logic loadIn;
    logic loadOut;
  } strobe_t;

  function automatic word_t rotL(word_t x, int n);
    return (x << n) | (x >> (LANE_W - n));
  endfunction

  function automatic word_t rotR(word_t x, int n);
    return (x >> n) | (x << (LANE_W - n));
  endfunction

  function automatic word_t smallS0(word_t x);
    return rotR(x, 7) ^ rotR(x, 18) ^ (x >> 3);
  endfunction

  function automatic word_t smallS1(word_t x);
    return rotR(x, 17) ^ rotR(x, 19) ^ (x >> 10);
  endfunction
endpackage

// File: rtl/sched_ctrl.sv
module sched_ctrl
  import sha_sched_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    inValid,
  output strobe_t strobe,
  output logic    outValid
);
  logic stageOne;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stageOne <= 1'b0;
      outValid <= 1'b0;
    end else begin
      stageOne <= inValid;
      outValid <= stageOne;
    end
  end

  always_comb begin
    strobe.loadIn  = inValid;
    strobe.loadOut = stageOne;
  end
endmodule

// File: rtl/sched_dp.sv
module sched_dp
  import sha_sched_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  strobe_t          strobe,
  input  op_t              opIn,
  input  logic [VEC_W-1:0] aIn,
  input  logic [VEC_W-1:0] bIn,
  output logic [VEC_W-1:0] resOut
);
  localparam int TOP = LANES - 1;

  logic [VEC_W-1:0] aReg, bReg;
  op_t              opReg;
  logic [VEC_W-1:0] resNext;
  word_t aw [LANES];
  word_t bw [LANES];
  word_t rw [LANES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      aReg  <= '0;
      bReg  <= '0;
      opReg <= '0;
    end else if (strobe.loadIn) begin
      aReg  <= aIn;
      bReg  <= bIn;
      opReg <= opIn;
    end
  end

  genvar g;
  generate
    for (g = 0; g < LANES; g++) begin : g_lane
      assign aw[g] = aReg[g*LANE_W +: LANE_W];
      assign bw[g] = bReg[g*LANE_W +: LANE_W];
      assign resNext[g*LANE_W +: LANE_W] = rw[g];
    end
  endgenerate

  always_comb begin
    for (int i = 0; i < LANES; i++) rw[i] = aw[i];
    case (opReg)
      OP_S1_EUPD: begin
        for (int i = 0; i < TOP; i++) rw[i] = bw[i];
        rw[TOP] = bw[TOP] + rotL(aw[TOP], 30);
      end
      OP_S1_XPA: begin
        rw[3] = aw[3] ^ aw[1];
        rw[2] = aw[2] ^ aw[0];
        rw[1] = aw[1] ^ bw[3];
        rw[0] = aw[0] ^ bw[2];
      end
      OP_S1_XPB: begin
        rw[3] = rotL(aw[3] ^ bw[2], 1);
        rw[2] = rotL(aw[2] ^ bw[1], 1);
        rw[1] = rotL(aw[1] ^ bw[0], 1);
        rw[0] = rotL(aw[0] ^ rw[3], 1);
      end
      OP_S2_XPA: begin
        for (int i = 0; i < LANES; i++)
          rw[i] = aw[i] + smallS0((i == TOP) ? bw[0] : aw[(i + 1) % LANES]);
      end
      OP_S2_XPB: begin
        rw[0] = aw[0] + smallS1(bw[2]);
        rw[1] = aw[1] + smallS1(bw[3]);
        rw[2] = aw[2] + smallS1(rw[0]);
        rw[3] = aw[3] + smallS1(rw[1]);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) resOut <= '0;
    else if (strobe.loadOut) resOut <= resNext;
  end
endmodule

// File: rtl/sha_sched_unit.sv
module sha_sched_unit
  import sha_sched_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inValid,
  input  logic [2:0]   opSel,
  input  logic [127:0] srcA,
  input  logic [127:0] srcB,
  output logic         outValid,
  output logic [127:0] result
);
  strobe_t strobe;

  sched_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .inValid  (inValid),
    .strobe   (strobe),
    .outValid (outValid)
  );

  sched_dp u_dp (
    .clk    (clk),
    .rst_n  (rst_n),
    .strobe (strobe),
    .opIn   (opSel),
    .aIn    (srcA),
    .bIn    (srcB),
    .resOut (result)
  );
endmodule

// File: rtl/sched_chk.sv
module sched_chk (
  input logic         clk,
  input logic         rst_n,
  input logic         inValid,
  input logic [2:0]   opSel,
  input logic [127:0] srcA,
  input logic [127:0] srcB,
  input logic         outValid,
  input logic [127:0] result
);
  logic [1:0]   vP;
  logic [2:0]   op0, op1;
  logic [127:0] a0, a1, b0, b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vP <= '0; op0 <= '0; op1 <= '0;
      a0 <= '0; a1 <= '0; b0 <= '0; b1 <= '0;
    end else begin
      vP <= {vP[0], inValid};
      if (inValid) begin op0 <= opSel; a0 <= srcA; b0 <= srcB; end
      if (vP[0])   begin op1 <= op0;   a1 <= a0;   b1 <= b0;   end
    end
  end

  // R1
  reset_state_chk: assert property (@(posedge clk) !rst_n |=> (!outValid && result == '0));

  // R2
  valid_latency_chk: assert property (@(posedge clk) disable iff (!rst_n) outValid == vP[1]);

  // R2
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) !outValid |-> $stable(result));

  // R3
  eupd_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid && op1 == 3'd0) |-> result[95:0] == b1[95:0]);

  // R4
  s1xpa_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid && op1 == 3'd1) |-> result[127:96] == (a1[127:96] ^ a1[63:32]));

  // R8
  reserved_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid && op1 >= 3'd5) |-> result == a1);
endmodule

bind sha_sched_unit sched_chk u_chk (.*);

// File: tb/sim_sha_sched_unit.sv
module sim_sha_sched_unit;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         inValid = 1'b0;
  logic [2:0]   opSel = '0;
  logic [127:0] srcA = '0;
  logic [127:0] srcB = '0;
  logic         outValid;
  logic [127:0] result;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  sha_sched_unit u0 (.*);

  function automatic logic [31:0] rl(logic [31:0] x, int n);
    logic [63:0] d = {x, x};
    return d[63-n -: 32];
  endfunction
  function automatic logic [31:0] rr(logic [31:0] x, int n);
    logic [63:0] d = {x, x};
    return d[31+n -: 32];
  endfunction
  function automatic logic [31:0] ln(logic [127:0] v, int n);
    return v[32*n +: 32];
  endfunction
  function automatic logic [31:0] e0(logic [31:0] x);
    return rr(x, 7) ^ rr(x, 18) ^ {3'b0, x[31:3]};
  endfunction
  function automatic logic [31:0] e1(logic [31:0] x);
    return rr(x, 17) ^ rr(x, 19) ^ {10'b0, x[31:10]};
  endfunction

  function automatic logic [127:0] model(logic [2:0] op, logic [127:0] a, logic [127:0] b);
    logic [31:0] l3, l2, l1, l0;
    case (op)
      3'd0: begin l3 = ln(b,3) + rl(ln(a,3), 30); l2 = ln(b,2); l1 = ln(b,1); l0 = ln(b,0); end
      3'd1: begin
        l3 = ln(a,1) ^ ln(a,3); l2 = ln(a,0) ^ ln(a,2);
        l1 = ln(b,3) ^ ln(a,1); l0 = ln(b,2) ^ ln(a,0);
      end
      3'd2: begin
        l3 = rl(ln(b,2) ^ ln(a,3), 1); l2 = rl(ln(b,1) ^ ln(a,2), 1);
        l1 = rl(ln(b,0) ^ ln(a,1), 1); l0 = rl(l3 ^ ln(a,0), 1);
      end
      3'd3: begin
        l0 = ln(a,0) + e0(ln(a,1)); l1 = ln(a,1) + e0(ln(a,2));
        l2 = ln(a,2) + e0(ln(a,3)); l3 = ln(a,3) + e0(ln(b,0));
      end
      3'd4: begin
        l0 = ln(a,0) + e1(ln(b,2)); l1 = ln(a,1) + e1(ln(b,3));
        l2 = ln(a,2) + e1(l0);      l3 = ln(a,3) + e1(l1);
      end
      default: return a;
    endcase
    return {l3, l2, l1, l0};
  endfunction

  function automatic string tagOf(logic [2:0] op);
    case (op)
      3'd0: return "R3";
      3'd1: return "R4";
      3'd2: return "R5";
      3'd3: return "R6";
      3'd4: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic check(string req, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic runOp(logic [2:0] op, logic [127:0] a, logic [127:0] b, string req);
    @(negedge clk);
    inValid = 1'b1; opSel = op; srcA = a; srcB = b;
    @(negedge clk);
    inValid = 1'b0; srcA = ~a; srcB = ~b; opSel = ~op;
    check("R2 no early valid", {127'b0, outValid}, 128'd0);
    @(negedge clk);
    check("R2 valid", {127'b0, outValid}, 128'd1);
    check(req, result, model(op, a, b));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [127:0] held, ea, eb;
    void'($urandom(32'h1234_5eed));
    repeat (3) @(negedge clk);
    check("R1 valid in reset", {127'b0, outValid}, 128'd0);
    check("R1 result in reset", result, 128'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 valid after reset", {127'b0, outValid}, 128'd0);
    check("R1 result after reset", result, 128'd0);

    // R9 lane carry corners
    runOp(3'd0, {32'hFFFF_FFFF, 96'h0}, {32'h0000_0001, 32'h1111_1111, 32'h2222_2222, 32'h3333_3333}, "R9 eupd wrap");
    check("R9 eupd lane", result, {32'h0, 32'h1111_1111, 32'h2222_2222, 32'h3333_3333});
    runOp(3'd3, {4{32'hFFFF_FFFF}}, {4{32'hFFFF_FFFF}}, "R9 s2xpa all ones");
    runOp(3'd4, {4{32'hFFFF_FFFF}}, {4{32'h8000_0001}}, "R9 s2xpb");
    // R5 chained lane: only B2 nonzero so lane 0 depends on new lane 3
    runOp(3'd2, 128'h0, {32'h0, 32'h8000_0000, 64'h0}, "R5 chain");
    check("R5 chain value", result, {32'h0000_0001, 32'h0, 32'h0, 32'h0000_0002});
    // R4 directed
    runOp(3'd1, {32'h1, 32'h2, 32'h4, 32'h8}, {32'h10, 32'h20, 64'h0}, "R4 directed");
    check("R4 value", result, {32'h5, 32'hA, 32'h14, 32'h28});
    // R8 reserved codes
    for (int c = 5; c < 8; c++)
      runOp(3'(c), {4{$urandom()}}, {4{$urandom()}}, "R8 reserved");

    // R2 hold while idle with changing operands
    held = result;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      srcA = {$urandom(), $urandom(), $urandom(), $urandom()};
      opSel = 3'(k);
    end
    @(negedge clk);
    check("R2 hold result", result, held);
    check("R2 idle valid", {127'b0, outValid}, 128'd0);

    // R2 back-to-back
    @(negedge clk);
    inValid = 1'b1; opSel = 3'd3; srcA = {4{32'h0123_4567}}; srcB = {4{32'h89AB_CDEF}};
    ea = srcA; eb = srcB;
    @(negedge clk);
    opSel = 3'd4; srcA = {4{32'hDEAD_BEEF}}; srcB = {4{32'h0F0F_F0F0}};
    @(negedge clk);
    inValid = 1'b0;
    check("R2 b2b first", result, model(3'd3, ea, eb));
    @(negedge clk);
    check("R2 b2b second valid", {127'b0, outValid}, 128'd1);
    check("R2 b2b second", result, model(3'd4, {4{32'hDEAD_BEEF}}, {4{32'h0F0F_F0F0}}));
    @(negedge clk);
    check("R2 b2b end", {127'b0, outValid}, 128'd0);

    // random sweep over all codes
    for (int n = 0; n < 400; n++) begin
      logic [2:0] op = 3'(n % 8);
      logic [127:0] ra = {$urandom(), $urandom(), $urandom(), $urandom()};
      logic [127:0] rb = {$urandom(), $urandom(), $urandom(), $urandom()};
      runOp(op, ra, rb, tagOf(op));
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule